// File: doc/BRIEF.md
# Dual Reloadable Down-Counting Timer

This block holds two independent 32-bit down-counters reached through a small memory-mapped register port, together with a write-to-clear interrupt cause register and an interrupt mask register. While a timer is enabled its counter drops by one on every clock. When the counter is at zero, the timer either reloads from its reload register (periodic use) or parks at zero and switches itself off (one-shot use). In both cases it sets its cause bit.

Timer 0 is normally set up as a free-running wrap source. Both its value and its reload are written with all ones and reload is enabled, and software reads the inverse of the value to get an up-counting view. Timer 1 is normally the event source. For one-shot use, software clears the cause, writes a delay into the value register, and sets the enable bit with reload off. For periodic use, it writes a reload of N-1 to get an event every N clocks. A single interrupt line reports any unmasked pending cause.

Top module: `twin_countdown_timer`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero and irq is low.
- R2: Register layout. Control is at 0x00, with bit 0 = timer 0 enable, bit 1 = timer 0 reload enable, bit 2 = timer 1 enable and bit 3 = timer 1 reload enable. Timer 0 reload is at 0x10 and its value at 0x14. Timer 1 reload is at 0x18 and its value at 0x1C. Cause is at 0x20 and mask is at 0x24. Written values read back. Unused bits, unmapped addresses and any cycle with rd low return zero. Read data is combinational in the cycle the read strobe is high.
- R3: An enabled timer whose counter is not zero decrements by exactly one per clock. A disabled timer holds its value.
- R4: With reload enabled, an enabled counter at zero loads the reload value on the next edge and raises an event. A reload of N-1 therefore gives one event every N clocks.
- R5: With reload disabled, an enabled counter at zero raises one event, stays at zero and clears its own enable bit in the control register. A control write in that same cycle takes precedence.
- R6: A write to a value register loads the written data on the next edge, even while the timer runs. Counting then continues from that value, and no event is raised in that cycle.
- R7: An event sets cause bit 1 (timer 0) or cause bit 2 (timer 1) whatever the mask holds. A write to the cause register clears each bit whose written data bit is 0 and keeps each bit written as 1. An event in the same cycle as a clear leaves the bit set.
- R8: Mask bits 1 and 2 are writable. irq is high exactly when some cause bit and its mask bit are both 1.
- R9: With reload set to 0xFFFFFFFF, the counter wraps from 0 to 0xFFFFFFFF and keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, acts on the next edge |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_rdata | output | 32 | Read data, zero when not reading |
| irq | output | 1 | OR of the unmasked cause bits |

## Verification
The embedded assertions watch every cycle for the following:
- single-step decrement of a running counter;
- reload on reaching zero in periodic use;
- parking at zero and self-disable in one-shot use;
- cause bits set by every expiry;
- cause bits staying set until a zero is written to them.

Several properties can only be shown by the bench scenarios, which compare against a behavioural model on every clock:
- the periodic event spacing;
- the full-width wrap;
- an expiry beating a same-cycle clear;
- masked versus unmasked interrupt behaviour;
- restarting a running timer by a value write;
- zero read data for unmapped addresses and unused bits.

// File: rtl/tmr_pkg.sv
// Shared constants for the dual down-counting timer: register offsets,
// control bit layout and cause bit positions. Assumes byte addressing with
// 32-bit registers on word boundaries.
package tmr_pkg;
    localparam int unsigned NUM_TMR   = 2;
    localparam int unsigned CTRL_W    = 2 * NUM_TMR;   // enable + reload-enable per timer
    localparam int unsigned CAUSE_LSB = 1;             // timer i owns cause/mask bit CAUSE_LSB+i
    localparam int unsigned CAUSE_W   = CAUSE_LSB + NUM_TMR;

    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_TBASE = 8'h10;          // first timer register pair
    localparam logic [7:0] OFS_CAUSE = 8'h20;
    localparam logic [7:0] OFS_MASK  = 8'h24;

    // Offset of the reload register of timer i.
    function automatic logic [7:0] rld_ofs(input int unsigned i);
        return 8'(32'(OFS_TBASE) + 8 * i);
    endfunction

    // Offset of the current-value register of timer i.
    function automatic logic [7:0] val_ofs(input int unsigned i);
        return 8'(32'(OFS_TBASE) + 8 * i + 4);
    endfunction
endpackage

// File: rtl/tmr_down_counter.sv
// One down-counter with its reload register.
// Assumes: run_i and reload_en_i come from the control register;
// a value write has priority over counting. expire_o is combinational and
// marks the cycle in which an enabled counter sits at zero; stop_o marks
// the same cycle when reload is off so the owner can clear the enable bit.
module tmr_down_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             reload_en_i,
    input  logic             reload_wr_i,
    input  logic             value_wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] reload_o,
    output logic [CNT_W-1:0] value_o,
    output logic             expire_o,
    output logic             stop_o
);
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] value_q;
    logic             at_zero;

    assign at_zero  = (value_q == '0);
    assign expire_o = run_i && at_zero && !value_wr_i;
    assign stop_o   = expire_o && !reload_en_i;
    assign reload_o = reload_q;
    assign value_o  = value_q;

    // Reload register: software-written only.
    always_ff @(posedge clk) begin
        if (!rst_n)           reload_q <= '0;
        else if (reload_wr_i) reload_q <= wdata_i;
    end

    // Counter: write, then reload or park at zero, else decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (value_wr_i) begin
            value_q <= wdata_i;
        end else if (run_i) begin
            if (at_zero) begin
                if (reload_en_i) value_q <= reload_q;
            end else begin
                value_q <= value_q - 1'b1;
            end
        end
    end

    // R3: running, nonzero counter steps down by one
    a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && !value_wr_i && !at_zero |=> value_q == $past(value_q) - 1'b1);

    // R4: periodic reload at zero takes the previous reload value
    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && reload_en_i && at_zero && !value_wr_i |=> value_q == $past(reload_q));

    // R5: one-shot parks at zero
    a_r5_park_zero: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && !reload_en_i && at_zero && !value_wr_i |=> value_q == '0);

    // R6: value write lands on the next edge
    a_r6_value_write: assert property (@(posedge clk) disable iff (!rst_n)
        value_wr_i |=> value_q == $past(wdata_i));
endmodule

// File: rtl/tmr_irq_unit.sv
// Interrupt cause and mask registers for the timers.
// Assumes: expire_i[k] is a one-cycle event for timer k. A write to cause
// clears only bits written as 0; an event in the same cycle wins.
// irq_o is the OR of unmasked cause bits.
module tmr_irq_unit #(
    parameter int unsigned NUM_TMR   = 2,
    parameter int unsigned CAUSE_LSB = 1,
    parameter int unsigned W         = CAUSE_LSB + NUM_TMR
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_TMR-1:0] expire_i,
    input  logic               cause_wr_i,
    input  logic               mask_wr_i,
    input  logic [W-1:0]       wdata_i,
    output logic [W-1:0]       cause_o,
    output logic [W-1:0]       mask_o,
    output logic               irq_o
);
    localparam logic [W-1:0] LIVE = W'(((2 ** NUM_TMR) - 1) << CAUSE_LSB);

    logic [W-1:0] cause_q;
    logic [W-1:0] mask_q;
    logic [W-1:0] set_vec;

    // Place the timer events at their cause bit positions.
    always_comb begin
        set_vec = '0;
        set_vec[CAUSE_LSB +: NUM_TMR] = expire_i;
    end

    // Cause: write-zero-to-clear, events dominate.
    always_ff @(posedge clk) begin
        if (!rst_n)          cause_q <= '0;
        else if (cause_wr_i) cause_q <= ((cause_q & wdata_i) | set_vec) & LIVE;
        else                 cause_q <= (cause_q | set_vec) & LIVE;
    end

    // Mask: plain writable bits at the live positions.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '0;
        else if (mask_wr_i) mask_q <= wdata_i & LIVE;
    end

    assign cause_o = cause_q;
    assign mask_o  = mask_q;
    assign irq_o   = |(cause_q & mask_q);

    for (genvar k = 0; k < NUM_TMR; k++) begin : g_chk
        // R7: every expiry sets its cause bit, mask notwithstanding
        a_r7_expiry_sets: assert property (@(posedge clk) disable iff (!rst_n)
            expire_i[k] |=> cause_q[CAUSE_LSB+k]);
        // R7: a set cause bit survives unless written as zero
        a_r7_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            cause_q[CAUSE_LSB+k] && !(cause_wr_i && !wdata_i[CAUSE_LSB+k])
            |=> cause_q[CAUSE_LSB+k]);
    end
endmodule

// File: rtl/twin_countdown_timer.sv
// Top of the dual down-counting timer. Decodes the register port, holds the
// control register, instantiates one counter per timer and the cause/mask
// unit, and drives the combinational read data.
// Assumes: one access per cycle; writes act on the next edge; read data is
// valid while bus_rd is high and zero otherwise.
module twin_countdown_timer #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    import tmr_pkg::*;

    localparam int unsigned CNT_W = DATA_W;

    logic [CTRL_W-1:0]  ctrl_q;
    logic               ctrl_wr;
    logic [NUM_TMR-1:0] expire;
    logic [NUM_TMR-1:0] stop;
    logic [CNT_W-1:0]   rld_arr [NUM_TMR];
    logic [CNT_W-1:0]   val_arr [NUM_TMR];
    logic [CAUSE_W-1:0] cause;
    logic [CAUSE_W-1:0] mask;

    assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        tmr_down_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk         (clk),
            .rst_n       (rst_n),
            .run_i       (ctrl_q[2*i]),
            .reload_en_i (ctrl_q[2*i+1]),
            .reload_wr_i (bus_wr && (bus_addr == ADDR_W'(rld_ofs(i)))),
            .value_wr_i  (bus_wr && (bus_addr == ADDR_W'(val_ofs(i)))),
            .wdata_i     (bus_wdata[CNT_W-1:0]),
            .reload_o    (rld_arr[i]),
            .value_o     (val_arr[i]),
            .expire_o    (expire[i]),
            .stop_o      (stop[i])
        );

        // R5: one-shot expiry clears its enable bit unless software writes control
        a_r5_self_disable: assert property (@(posedge clk) disable iff (!rst_n)
            stop[i] && !ctrl_wr |=> !ctrl_q[2*i]);
    end

    // Control register: software write wins over the one-shot self-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= bus_wdata[CTRL_W-1:0];
        end else begin
            for (int i = 0; i < NUM_TMR; i++) begin
                if (stop[i]) ctrl_q[2*i] <= 1'b0;
            end
        end
    end

    tmr_irq_unit #(.NUM_TMR(NUM_TMR), .CAUSE_LSB(CAUSE_LSB), .W(CAUSE_W)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire_i   (expire),
        .cause_wr_i (bus_wr && (bus_addr == ADDR_W'(OFS_CAUSE))),
        .mask_wr_i  (bus_wr && (bus_addr == ADDR_W'(OFS_MASK))),
        .wdata_i    (bus_wdata[CAUSE_W-1:0]),
        .cause_o    (cause),
        .mask_o     (mask),
        .irq_o      (irq)
    );

    // Read mux: zero for idle cycles, unmapped addresses and unused bits.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == ADDR_W'(OFS_CTRL))  bus_rdata = DATA_W'(ctrl_q);
            if (bus_addr == ADDR_W'(OFS_CAUSE)) bus_rdata = DATA_W'(cause);
            if (bus_addr == ADDR_W'(OFS_MASK))  bus_rdata = DATA_W'(mask);
            for (int i = 0; i < NUM_TMR; i++) begin
                if (bus_addr == ADDR_W'(rld_ofs(i))) bus_rdata = DATA_W'(rld_arr[i]);
                if (bus_addr == ADDR_W'(val_ofs(i))) bus_rdata = DATA_W'(val_arr[i]);
            end
        end
    end
endmodule

// File: tb/twin_countdown_timer_bench.sv
`timescale 1ns/1ps
// Bench for twin_countdown_timer: a behavioural model is stepped on every
// clock and compared with irq and read data on every cycle. Hand-computed
// expectations are added at the corner cases.
module twin_countdown_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  b_addr = '0;
    logic [31:0] b_wdata = '0;
    logic        b_wr = 1'b0;
    logic        b_rd = 1'b0;
    logic [31:0] b_rdata;
    logic        irq;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    twin_countdown_timer u_twin_countdown_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wdata(b_wdata),
        .bus_wr(b_wr), .bus_rd(b_rd), .bus_rdata(b_rdata), .irq(irq)
    );

    // Behavioural reference state
    logic [31:0] m_val [2];
    logic [31:0] m_rld [2];
    logic [3:0]  m_ctrl;
    logic [2:0]  m_cause;
    logic [2:0]  m_mask;
    logic [1:0]  m_ev, m_stp;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_val[0] = 0; m_val[1] = 0; m_rld[0] = 0; m_rld[1] = 0;
            m_ctrl = 0; m_cause = 0; m_mask = 0;
        end else begin
            m_ev = 0; m_stp = 0;
            for (int i = 0; i < 2; i++) begin
                if (b_wr && b_addr == 8'h14 + 8*i) m_val[i] = b_wdata;
                else if (m_ctrl[2*i]) begin
                    if (m_val[i] == 0) begin
                        m_ev[i] = 1'b1;
                        if (m_ctrl[2*i+1]) m_val[i] = m_rld[i];
                        else m_stp[i] = 1'b1;
                    end else m_val[i] = m_val[i] - 1;
                end
                if (b_wr && b_addr == 8'h10 + 8*i) m_rld[i] = b_wdata;
            end
            if (b_wr && b_addr == 8'h00) m_ctrl = b_wdata[3:0];
            else for (int i = 0; i < 2; i++) if (m_stp[i]) m_ctrl[2*i] = 1'b0;
            if (b_wr && b_addr == 8'h20) m_cause = m_cause & b_wdata[2:0];
            m_cause = m_cause | {m_ev, 1'b0};
            if (b_wr && b_addr == 8'h24) m_mask = b_wdata[2:0] & 3'b110;
        end
    end

    function automatic logic [31:0] exp_read(input logic [7:0] a, input logic r);
        if (!r) return 0;
        case (a)
            8'h00: return {28'd0, m_ctrl};
            8'h10: return m_rld[0];
            8'h14: return m_val[0];
            8'h18: return m_rld[1];
            8'h1C: return m_val[1];
            8'h20: return {29'd0, m_cause};
            8'h24: return {29'd0, m_mask};
            default: return 0;
        endcase
    endfunction

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", cur_req, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare just after.
    task automatic step(input logic [7:0] a, input logic [31:0] d, input logic w, input logic r);
        @(negedge clk);
        b_addr = a; b_wdata = d; b_wr = w; b_rd = r;
        #1;
        check("irq", {31'd0, irq}, {31'd0, |(m_cause & m_mask)});
        check("rdata", b_rdata, exp_read(a, r));
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(a, d, 1'b1, 1'b0);
    endtask

    task automatic rd_exp(input logic [7:0] a, input logic [31:0] lit);
        step(a, 0, 1'b0, 1'b1);
        check("literal", b_rdata, lit);
    endtask

    task automatic watch(input logic [7:0] a, input int n);
        for (int k = 0; k < n; k++) step(a, 0, 1'b0, 1'b1);
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every register
        cur_req = "R1";
        rd_exp(8'h00, 0); rd_exp(8'h14, 0); rd_exp(8'h1C, 0);
        rd_exp(8'h20, 0); rd_exp(8'h24, 0);

        // R2: readback, unused bits, unmapped addresses, idle read
        cur_req = "R2";
        wr(8'h10, 32'hDEAD_BEEF); wr(8'h18, 32'h1234_5678);
        wr(8'h14, 32'h0000_0055); wr(8'h1C, 32'hA5A5_0000);
        rd_exp(8'h10, 32'hDEAD_BEEF); rd_exp(8'h18, 32'h1234_5678);
        rd_exp(8'h14, 32'h55); rd_exp(8'h1C, 32'hA5A5_0000);
        wr(8'h00, 32'hFFFF_FFF0); rd_exp(8'h00, 0);
        wr(8'h24, 32'hFFFF_FFFF); rd_exp(8'h24, 32'h6);
        rd_exp(8'h08, 0); rd_exp(8'h28, 0); rd_exp(8'h04, 0);
        step(8'h10, 0, 1'b0, 1'b0); check("idle", b_rdata, 0);
        wr(8'h24, 0);

        // R3: decrement while enabled, hold while disabled
        cur_req = "R3";
        wr(8'h14, 32'd10); wr(8'h00, 32'h1);
        rd_exp(8'h14, 10); rd_exp(8'h14, 9); rd_exp(8'h14, 8);
        wr(8'h00, 32'h0);
        rd_exp(8'h14, 6); rd_exp(8'h14, 6); rd_exp(8'h14, 6);

        // R4: periodic timer 1, reload 4 -> event every 5 clocks
        cur_req = "R4";
        wr(8'h20, 0);
        wr(8'h18, 32'd4); wr(8'h1C, 32'd4); wr(8'h00, 32'hC);
        begin
            logic [31:0] seq [10] = '{4, 3, 2, 1, 0, 4, 3, 2, 1, 0};
            for (int k = 0; k < 10; k++) rd_exp(8'h1C, seq[k]);
        end
        rd_exp(8'h20, 32'h4);
        wr(8'h24, 32'h4); watch(8'h1C, 12);

        // R8: masked cause leaves irq low, unmasked raises it
        cur_req = "R8";
        wr(8'h00, 0); wr(8'h24, 32'h2); watch(8'h20, 2);
        check("irq masked", {31'd0, irq}, 0);
        wr(8'h24, 32'h4); watch(8'h20, 1);
        check("irq unmasked", {31'd0, irq}, 1);
        wr(8'h20, 0); watch(8'h20, 1);
        check("irq cleared", {31'd0, irq}, 0);

        // R5: one-shot timer 1 with delay 3
        cur_req = "R5";
        wr(8'h1C, 32'd3); wr(8'h00, 32'h4);
        watch(8'h1C, 6);
        rd_exp(8'h1C, 0); rd_exp(8'h00, 0); rd_exp(8'h20, 32'h4);
        wr(8'h20, 0); watch(8'h20, 3); rd_exp(8'h20, 0);

        // R6: value write while running restarts countdown
        cur_req = "R6";
        wr(8'h1C, 32'd100); wr(8'h00, 32'h4); watch(8'h1C, 3);
        wr(8'h1C, 32'd7);
        rd_exp(8'h1C, 7); rd_exp(8'h1C, 6);
        wr(8'h00, 0);

        // R7: expiry wins over same-cycle clear; selective clear
        cur_req = "R7";
        wr(8'h14, 0); wr(8'h00, 32'h1);
        wr(8'h20, 0);
        rd_exp(8'h20, 32'h2); rd_exp(8'h00, 0);
        wr(8'h1C, 0); wr(8'h00, 32'h4); watch(8'h20, 1);
        rd_exp(8'h20, 32'h6);
        wr(8'h20, 32'h4); rd_exp(8'h20, 32'h4);
        wr(8'h20, 32'h2); rd_exp(8'h20, 32'h0);

        // R9: full-width wrap of timer 0
        cur_req = "R9";
        wr(8'h10, 32'hFFFF_FFFF); wr(8'h14, 32'd2); wr(8'h00, 32'h3);
        rd_exp(8'h14, 2); rd_exp(8'h14, 1); rd_exp(8'h14, 0);
        rd_exp(8'h14, 32'hFFFF_FFFF); rd_exp(8'h14, 32'hFFFF_FFFE);
        wr(8'h24, 32'h6); watch(8'h20, 4);
        wr(8'h00, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule